// File: doc/BRIEF.md
# Masked Burst Address Counter

This block produces the address for one port of a synchronous memory during burst access. An 18-bit counter steps through a field of low-order address bits. A mask register, made of contiguous ones, selects that field. The bits above the field keep whatever value was last loaded. When the field reaches its all-ones value, the next increment does not roll over to zero. It returns to the start address held in a mirror register, so the same block of words can be read again without reloading the start address.

Each clock the port presents one command:
- hold
- increment
- counter reset
- counter load
- mask reset
- mask load
- mask readback

An active-low interrupt reports that an increment has left the field all ones. A pipelined readback bus shows the mask one cycle after it is requested. During that cycle the block asks for the data bus to be tri-stated if the port is enabled. If a mask shape is loaded that cannot count correctly, the block still stores it and raises a sticky error flag.

Top module: `burst_ctr`

## Requirements
- R1: On master reset (`rst_n` low) the counter and mirror become zero, the mask becomes all ones, `cnt_int_n_o` is high, `mask_err_o` is low and `mask_rb_vld_o` is low.
- R2: Command 4 (mask reset) sets the mask to all ones. Command 5 (mask load) copies `addr_i` into the mask. Both take effect at the clock edge that samples the command.
- R3: Command encoding on `cmd_i`: 0 hold, 1 increment, 2 counter reset, 3 counter load, 4 mask reset, 5 mask load, 6 mask readback, 7 acts as hold.
- R4: Counter load stores `addr_i` in both the counter and the mirror. `addr_o` shows the value one cycle after the command.
- R5: On increment, if the masked field of the counter is all ones, the field takes the mirror's field value (wrap). Otherwise the field advances by the step.
- R6: When mask bit 0 is 0, each increment advances the counter by two and counter bit 0 keeps its value. When mask bit 0 is 1, the step is one.
- R7: After an increment, `cnt_int_n_o` is low if the masked field of the new count is all ones, and high otherwise. It updates in the cycle after the command.
- R8: Counter reset, counter load, mask reset, mask load and master reset all drive `cnt_int_n_o` high.
- R9: For one cycle after a readback command, `mask_rb_vld_o` is high and `mask_rb_o` carries the mask. Otherwise `mask_rb_o` is zero. `dq_hiz_o` is high exactly when `mask_rb_vld_o` and `port_en_i` are both high.
- R10: Counter bits outside the mask keep their value through increments and wraps.
- R11: Counter reset clears the masked bits of the counter, keeps the other bits, and loads the mirror with the result.
- R12: A mask is legal when it is nonzero and has the form 2^n-1 or 2^n-2. Loading an illegal mask still stores it, and sets `mask_err_o`, which stays high until master reset.
- R13: Hold, readback and code 7 leave the counter, the mirror and `cnt_int_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low master reset, synchronous |
| cmd_i | input | 3 | Command code for this cycle |
| addr_i | input | ADDR_W | Address or mask value for load commands |
| port_en_i | input | 1 | Port enabled (chip enables active) |
| addr_o | output | ADDR_W | Current counter value |
| cnt_int_n_o | output | 1 | Active-low all-ones field interrupt |
| mask_rb_o | output | ADDR_W | Mask readback bus |
| mask_rb_vld_o | output | 1 | Readback bus valid |
| dq_hiz_o | output | 1 | Request to tri-state the data bus |
| mask_err_o | output | 1 | Sticky illegal-mask flag |

## Verification
The bench builds the block with the default `ADDR_W` of 18. At that width every legal mask shape can be swept: 18 shapes of the form 2^n-1 and 17 of the form 2^n-2. For each shape the bench loads a start address a few steps below the field maximum, so the interrupt edge, the wrap back to the mirror and the preserved upper bits are all reached in a handful of increments, even for the widest field. A randomized phase then mixes all commands, including readback with the port enabled and disabled. A behavioural model is checked against the block on every clock throughout.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

    typedef enum logic [2:0] {
        CMD_HOLD  = 3'd0,
        CMD_INC   = 3'd1,
        CMD_CRST  = 3'd2,
        CMD_CLOAD = 3'd3,
        CMD_MRST  = 3'd4,
        CMD_MLOAD = 3'd5,
        CMD_MREAD = 3'd6,
        CMD_RSVD  = 3'd7
    } ctr_cmd_e;

endpackage

// File: rtl/bc_mask_reg.sv
module bc_mask_reg
    import burst_ctr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctr_cmd_e          cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] mask_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
    localparam logic [ADDR_W:0]   ONE_EXT  = {{ADDR_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [ADDR_W-1:0] mask;
        logic              err;
    } mask_state_t;

    mask_state_t st_q, st_d;
    logic [ADDR_W:0] filled_ext;
    logic            shape_ok;

    // A legal shape becomes a solid run of low ones once bit 0 is forced.
    always_comb begin
        filled_ext = {1'b0, addr_i} | ONE_EXT;
        shape_ok   = (addr_i != '0) && ((filled_ext & (filled_ext + ONE_EXT)) == '0);
    end

    always_comb begin
        st_d = st_q;
        unique case (cmd_i)
            CMD_MRST:  st_d.mask = ALL_ONES;
            CMD_MLOAD: begin
                st_d.mask = addr_i;
                if (!shape_ok) begin
                    st_d.err = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= ALL_ONES;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign err_o  = st_q.err;

    AST_MRST_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MRST) |=> (mask_o == ALL_ONES)); // R2
    AST_MLOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MLOAD) |=> (mask_o == $past(addr_i))); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R12

endmodule

// File: rtl/bc_counter.sv
module bc_counter
    import burst_ctr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctr_cmd_e          cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] mask_i,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              int_n_o
);

    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] mir;
        logic              int_n;
    } ctr_state_t;

    ctr_state_t st_q, st_d;

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] kept_bits;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] inc_next;
    logic              field_full;

    // Increment datapath: the upper bits are held and only the field changes.
    always_comb begin
        step       = mask_i[0] ? STEP_ONE : STEP_TWO;
        kept_bits  = st_q.cnt & ~mask_i;
        field_full = ((st_q.cnt & mask_i) == mask_i);
        stepped    = (st_q.cnt + step) & mask_i;
        inc_next   = field_full ? (kept_bits | (st_q.mir & mask_i))
                                : (kept_bits | stepped);
    end

    always_comb begin
        st_d = st_q;
        unique case (cmd_i)
            CMD_INC: begin
                st_d.cnt   = inc_next;
                st_d.int_n = ((inc_next & mask_i) != mask_i);
            end
            CMD_CRST: begin
                st_d.cnt   = kept_bits;
                st_d.mir   = kept_bits;
                st_d.int_n = 1'b1;
            end
            CMD_CLOAD: begin
                st_d.cnt   = addr_i;
                st_d.mir   = addr_i;
                st_d.int_n = 1'b1;
            end
            CMD_MRST, CMD_MLOAD: st_d.int_n = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.mir   <= '0;
            st_q.int_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign int_n_o = st_q.int_n;

    AST_CLOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_CLOAD) |=> (cnt_o == $past(addr_i))); // R4
    AST_INT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i inside {CMD_CRST, CMD_CLOAD, CMD_MRST, CMD_MLOAD}) |=> int_n_o); // R8
    AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_INC) |=> (((cnt_o ^ $past(cnt_o)) & ~$past(mask_i)) == '0)); // R10
    AST_BIT0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_INC && !mask_i[0]) |=> (cnt_o[0] == $past(cnt_o[0]))); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i inside {CMD_HOLD, CMD_MREAD, CMD_RSVD}) |=> ($stable(cnt_o) && $stable(int_n_o))); // R13

endmodule

// File: rtl/bc_readback.sv
module bc_readback
    import burst_ctr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctr_cmd_e          cmd_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic              port_en_i,
    output logic [ADDR_W-1:0] rb_o,
    output logic              rb_vld_o,
    output logic              hiz_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] rb;
        logic              vld;
    } rb_state_t;

    rb_state_t st_q, st_d;

    always_comb begin
        st_d.vld = (cmd_i == CMD_MREAD);
        st_d.rb  = (cmd_i == CMD_MREAD) ? mask_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rb  <= '0;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rb_o     = st_q.rb;
    assign rb_vld_o = st_q.vld;
    assign hiz_o    = st_q.vld & port_en_i;

    AST_RB_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MREAD) |=> (rb_vld_o && rb_o == $past(mask_i))); // R9
    AST_RB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_MREAD) |=> (!rb_vld_o && !hiz_o)); // R9

endmodule

// File: rtl/burst_ctr.sv
module burst_ctr
    import burst_ctr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              port_en_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cnt_int_n_o,
    output logic [ADDR_W-1:0] mask_rb_o,
    output logic              mask_rb_vld_o,
    output logic              dq_hiz_o,
    output logic              mask_err_o
);

    ctr_cmd_e          cmd;
    logic [ADDR_W-1:0] mask;

    assign cmd = ctr_cmd_e'(cmd_i);

    bc_mask_reg #(.ADDR_W(ADDR_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .addr_i (addr_i),
        .mask_o (mask),
        .err_o  (mask_err_o)
    );

    bc_counter #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .addr_i  (addr_i),
        .mask_i  (mask),
        .cnt_o   (addr_o),
        .int_n_o (cnt_int_n_o)
    );

    bc_readback #(.ADDR_W(ADDR_W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .mask_i    (mask),
        .port_en_i (port_en_i),
        .rb_o      (mask_rb_o),
        .rb_vld_o  (mask_rb_vld_o),
        .hiz_o     (dq_hiz_o)
    );

endmodule

// File: tb/burst_ctr_tb_top.sv
module burst_ctr_tb_top;

    localparam int W = 18;

    localparam logic [2:0] C_HOLD  = 3'd0;
    localparam logic [2:0] C_INC   = 3'd1;
    localparam logic [2:0] C_CRST  = 3'd2;
    localparam logic [2:0] C_CLOAD = 3'd3;
    localparam logic [2:0] C_MRST  = 3'd4;
    localparam logic [2:0] C_MLOAD = 3'd5;
    localparam logic [2:0] C_MREAD = 3'd6;
    localparam logic [2:0] C_RSVD  = 3'd7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic [2:0]   cmd;
    logic [W-1:0] addr;
    logic         en;
    logic [W-1:0] addr_o;
    logic         int_n;
    logic [W-1:0] rb;
    logic         rb_vld;
    logic         hiz;
    logic         err;

    burst_ctr #(.ADDR_W(W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .addr_i        (addr),
        .port_en_i     (en),
        .addr_o        (addr_o),
        .cnt_int_n_o   (int_n),
        .mask_rb_o     (rb),
        .mask_rb_vld_o (rb_vld),
        .dq_hiz_o      (hiz),
        .mask_err_o    (err)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [W-1:0] m_cnt, m_mir, m_mask, m_rb;
    logic         m_int, m_err, m_rbv;

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit legal_shape(input logic [W-1:0] v);
        bit ok = 1'b0;
        for (int n = 1; n <= W; n++) begin
            logic [W:0] p = (W+1)'(1) << n;
            if ({1'b0, v} == p - 1) ok = 1'b1;
            if (n >= 2 && {1'b0, v} == p - 2) ok = 1'b1;
        end
        return ok;
    endfunction

    // Behavioural model: the field is shifted down, counted as a number, shifted back.
    task automatic model_step(input logic [2:0] c, input logic [W-1:0] a);
        int lo;
        logic [W-1:0] f, fmax, nf;
        m_rbv = (c == C_MREAD);
        m_rb  = (c == C_MREAD) ? m_mask : '0;
        case (c)
            C_INC: begin
                lo   = m_mask[0] ? 0 : 1;
                f    = (m_cnt & m_mask) >> lo;
                fmax = m_mask >> lo;
                nf   = (f == fmax) ? ((m_mir & m_mask) >> lo) : f + 1;
                m_cnt = (m_cnt & ~m_mask) | ((nf << lo) & m_mask);
                m_int = (nf != fmax);
            end
            C_CRST: begin
                m_cnt = m_cnt & ~m_mask;
                m_mir = m_cnt;
                m_int = 1'b1;
            end
            C_CLOAD: begin
                m_cnt = a; m_mir = a; m_int = 1'b1;
            end
            C_MRST: begin
                m_mask = '1; m_int = 1'b1;
            end
            C_MLOAD: begin
                m_mask = a; m_int = 1'b1;
                if (!legal_shape(a)) m_err = 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic compare_all();
        chk("R5", "addr_o", addr_o, m_cnt);
        chk("R7", "cnt_int_n", W'(int_n), W'(m_int));
        chk("R9", "rb_vld", W'(rb_vld), W'(m_rbv));
        chk("R9", "mask_rb", rb, m_rb);
        chk("R9", "dq_hiz", W'(hiz), W'(m_rbv & en));
        chk("R12", "mask_err", W'(err), W'(m_err));
    endtask

    task automatic cyc(input logic [2:0] c, input logic [W-1:0] a, input logic e);
        @(negedge clk);
        cmd = c; addr = a; en = e;
        @(posedge clk);
        model_step(c, a);
        #2;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd = C_HOLD; addr = '0; en = 1'b0;
        m_cnt = '0; m_mir = '0; m_mask = '1; m_int = 1'b1;
        m_err = 1'b0; m_rbv = 1'b0; m_rb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "addr_o", addr_o, '0);
        chk("R1", "cnt_int_n", W'(int_n), W'(1));
        chk("R1", "mask_err", W'(err), W'(0));
        chk("R1", "rb_vld", W'(rb_vld), W'(0));
        cyc(C_MREAD, '0, 1'b1);
        chk("R1", "mask after reset", rb, {W{1'b1}});
        chk("R9", "dq_hiz enabled", W'(hiz), W'(1));
        cyc(C_MREAD, '0, 1'b0);
        chk("R9", "dq_hiz disabled", W'(hiz), W'(0));

        // R5 R6 R7 R10: sweep every legal mask shape
        for (int n = 1; n <= W; n++) begin
            for (int k = 0; k < 2; k++) begin
                logic [W-1:0] msk, fmax, f0, start;
                int lo;
                if (k == 1 && n < 2) continue;
                msk  = W'(((W+1)'(1) << n) - ((k == 0) ? 1 : 2));
                lo   = (k == 0) ? 0 : 1;
                fmax = msk >> lo;
                f0   = (fmax >= 3) ? fmax - 3 : '0;
                start = (W'($urandom) & ~msk) | ((f0 << lo) & msk);
                if (lo == 1) start[0] = 1'($urandom);
                cyc(C_MLOAD, msk, 1'b0);
                cyc(C_MREAD, '0, 1'b1);
                cyc(C_CLOAD, start, 1'b0);
                for (int i = 0; i < 7; i++) cyc(C_INC, '0, 1'b0);
                cyc(C_HOLD, '0, 1'b0);
            end
        end

        // R4 R10 R7 R5: field of four bits
        cyc(C_MLOAD, W'(18'h0000F), 1'b0);
        cyc(C_CLOAD, W'(18'h12345), 1'b0);
        chk("R4", "load", addr_o, W'(18'h12345));
        cyc(C_INC, '0, 1'b0);
        chk("R10", "upper kept", addr_o, W'(18'h12346));
        for (int i = 0; i < 9; i++) cyc(C_INC, '0, 1'b0);
        chk("R7", "field max addr", addr_o, W'(18'h1234F));
        chk("R7", "int low", W'(int_n), W'(0));
        cyc(C_INC, '0, 1'b0);
        chk("R5", "wrap to mirror", addr_o, W'(18'h12345));
        chk("R7", "int high after wrap", W'(int_n), W'(1));

        // R6 R11: count by two, counter reset
        cyc(C_MLOAD, W'(18'h003FE), 1'b0);
        cyc(C_CLOAD, W'(18'h2A001), 1'b0);
        cyc(C_INC, '0, 1'b0);
        chk("R6", "step two", addr_o, W'(18'h2A003));
        cyc(C_CRST, '0, 1'b0);
        chk("R11", "counter reset", addr_o, W'(18'h2A001));
        cyc(C_INC, '0, 1'b0);
        cyc(C_INC, '0, 1'b0);
        chk("R6", "step two again", addr_o, W'(18'h2A005));

        // R13 R8 R3: idle commands, interrupt release
        cyc(C_MLOAD, W'(18'h00001), 1'b0);
        cyc(C_CLOAD, '0, 1'b0);
        cyc(C_INC, '0, 1'b0);
        chk("R7", "one-bit field int", W'(int_n), W'(0));
        cyc(C_HOLD, '0, 1'b0);
        chk("R13", "hold addr", addr_o, W'(1));
        chk("R13", "hold int", W'(int_n), W'(0));
        cyc(C_MREAD, '0, 1'b1);
        chk("R13", "readback int", W'(int_n), W'(0));
        cyc(C_RSVD, W'(18'h3FFFF), 1'b0);
        chk("R3", "code 7 as hold", addr_o, W'(1));
        cyc(C_MLOAD, W'(18'h00001), 1'b0);
        chk("R8", "mask load releases int", W'(int_n), W'(1));

        // R12 R2: illegal mask
        cyc(C_MLOAD, W'(18'h003FC), 1'b0);
        chk("R12", "err set", W'(err), W'(1));
        cyc(C_MREAD, '0, 1'b0);
        chk("R12", "illegal stored", rb, W'(18'h003FC));
        cyc(C_MRST, '0, 1'b0);
        cyc(C_MREAD, '0, 1'b0);
        chk("R2", "mask reset ones", rb, {W{1'b1}});
        chk("R12", "err sticky", W'(err), W'(1));

        // Randomized mix with legal masks
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            logic [2:0] c;
            logic [W-1:0] a = W'($urandom);
            case (sel)
                0: c = C_HOLD;
                1, 2, 3: c = C_INC;
                4: c = C_CRST;
                5: c = C_CLOAD;
                6: c = C_MRST;
                7: begin
                    int nn = $urandom_range(2, 6);
                    c = C_MLOAD;
                    a = W'((1 << nn) - 1 - $urandom_range(0, 1));
                end
                8: c = C_MREAD;
                default: c = C_RSVD;
            endcase
            cyc(c, a, 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule